// File: doc/BRIEF.md
# Track Occupancy Hazard Monitor

This block watches the occupancy state of a stretch of track and raises an alarm whenever that state shows a collision, a derailment or a train picture that cannot physically exist. Every linear section reports one 3-bit code for each travel direction. Every point reports one code for each way a train can enter it (from the stem, from the plus leg, from the minus leg), together with the position of its blades. The monitor evaluates all of these every clock. It does not model trains; it only judges the codes it is given.

Linear sections are numbered along the up direction. A parameter mask states which neighbouring pairs are physically joined. Only joined pairs take part in the train integrity test, which runs in both directions. The results are captured into one registered hazard bit per linear section and one per point. A single summary flag latches the first hazard and holds it until reset, so a supervisor can poll one bit.

Top module: `trk_hazard_mon`

## Requirements
- R1: While reset is asserted and right after its release, `hazard`, `lin_haz` and `pnt_haz` are all zero.
- R2: Each code uses bit 2 for "train front inside", bit 1 for "train rear inside" and bit 0 for "occupied". Every per-section and per-point hazard bit is registered: it reflects the inputs present at the previous rising clock edge and returns to zero when the cause goes away.
- R3: A linear section is flagged when its up-travel code and its down-travel code are both nonzero.
- R4: Point position encoding is PLUS = 0, MINUS = 1, MOVING = 2. A point is flagged when its plus-entry code is nonzero while the position is not PLUS.
- R5: A point is flagged when its minus-entry code is nonzero while position bit 0 is clear (PLUS or MOVING).
- R6: A point is flagged when its stem-entry code is nonzero while position bit 1 is set (MOVING).
- R7: For sections i and i+1 joined by `LINK_UP[i]`, section i is flagged when "up code of i AND 3'b101 equals 3'b001" differs from "up code of i+1 AND 3'b011 equals 3'b001".
- R8: For sections i and i+1 joined by `LINK_UP[i]`, section i+1 is flagged when "down code of i+1 AND 3'b101 equals 3'b001" differs from "down code of i AND 3'b011 equals 3'b001".
- R9: Where `LINK_UP[i]` is 0, no integrity test is made across sections i and i+1.
- R10: `hazard` rises in the same cycle as the first hazard bit and stays at 1 until reset, even after all causes disappear.
- R11: A code of 3'b111 (front and rear of one train inside, or two train segments meeting at a joint) in one direction only, with consistent neighbours, raises no hazard.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| occ_up | input | 3*NUM_LIN | Up-travel code per linear section, section i at bits 3i+2..3i |
| occ_dn | input | 3*NUM_LIN | Down-travel code per linear section |
| pnt_stem_in | input | 3*NUM_PNT | Code for trains entering each point from its stem |
| pnt_plus_in | input | 3*NUM_PNT | Code for trains entering each point from its plus leg |
| pnt_minus_in | input | 3*NUM_PNT | Code for trains entering each point from its minus leg |
| pnt_lie | input | 2*NUM_PNT | Actual position of each point |
| lin_haz | output | NUM_LIN | Registered hazard bit per linear section |
| pnt_haz | output | NUM_PNT | Registered derailment bit per point |
| hazard | output | 1 | Sticky summary alarm |

## Verification
All three outputs are due exactly one rising edge after the inputs that cause them: the per-section and per-point bits come from one register stage, and the sticky flag is captured at the same edge. The bench changes inputs on a falling edge, lets one rising edge pass and compares on the next falling edge, before the following vector is applied. The expected sticky value is accumulated over the vectors since the last reset, and the clearing of the per-section bits is checked in the same cycle as the flag holding.

// File: rtl/trk_haz_pkg.sv
package trk_haz_pkg;
  localparam int CODE_W = 3;
  localparam int LIE_W  = 2;

  localparam logic [LIE_W-1:0] LIE_PLUS   = 2'd0;
  localparam logic [LIE_W-1:0] LIE_MINUS  = 2'd1;
  localparam logic [LIE_W-1:0] LIE_MOVING = 2'd2;

  // bit 2 = front inside, bit 1 = rear inside, bit 0 = occupied
  function automatic logic code_live(input logic [CODE_W-1:0] c);
    return |c;
  endfunction

  function automatic logic body_no_front(input logic [CODE_W-1:0] c);
    return c[0] & ~c[2];
  endfunction

  function automatic logic body_no_rear(input logic [CODE_W-1:0] c);
    return c[0] & ~c[1];
  endfunction

  // a train body running past the far end of 'behind' must be seen
  // arriving without its rear in 'ahead', and the other way round
  function automatic logic seam_broken(input logic [CODE_W-1:0] behind,
                                       input logic [CODE_W-1:0] ahead);
    return body_no_front(behind) ^ body_no_rear(ahead);
  endfunction

  function automatic logic wrong_lie(input logic [LIE_W-1:0]  lie,
                                     input logic [CODE_W-1:0] stem,
                                     input logic [CODE_W-1:0] plus,
                                     input logic [CODE_W-1:0] minus);
    logic from_plus, from_minus, from_stem;
    from_plus  = code_live(plus)  && (lie != LIE_PLUS);
    from_minus = code_live(minus) && !lie[0];
    from_stem  = code_live(stem)  && lie[1];
    return from_plus | from_minus | from_stem;
  endfunction
endpackage

// File: rtl/trk_lin_check.sv
module trk_lin_check
  import trk_haz_pkg::*;
(
  input  logic [CODE_W-1:0] occ_up,
  input  logic [CODE_W-1:0] occ_dn,
  input  logic [CODE_W-1:0] up_ahead,
  input  logic [CODE_W-1:0] dn_ahead,
  input  logic              link_up,
  input  logic              link_dn,
  output logic              evt_h2h,
  output logic              evt_seam,
  output logic              evt
);
  logic seam_up, seam_dn;

  always_comb begin
    evt_h2h  = code_live(occ_up) & code_live(occ_dn);
    seam_up  = link_up & seam_broken(occ_up, up_ahead);
    seam_dn  = link_dn & seam_broken(occ_dn, dn_ahead);
    evt_seam = seam_up | seam_dn;
    evt      = evt_h2h | evt_seam;
  end
endmodule

// File: rtl/trk_pnt_check.sv
module trk_pnt_check
  import trk_haz_pkg::*;
(
  input  logic [LIE_W-1:0]  lie,
  input  logic [CODE_W-1:0] stem_in,
  input  logic [CODE_W-1:0] plus_in,
  input  logic [CODE_W-1:0] minus_in,
  output logic              evt
);
  always_comb evt = wrong_lie(lie, stem_in, plus_in, minus_in);
endmodule

// File: rtl/trk_hazard_mon.sv
module trk_hazard_mon
  import trk_haz_pkg::*;
#(
  parameter int NUM_LIN = 6,
  parameter int NUM_PNT = 3,
  parameter logic [NUM_LIN-2:0] LINK_UP = 5'b11011
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_LIN*CODE_W-1:0] occ_up,
  input  logic [NUM_LIN*CODE_W-1:0] occ_dn,
  input  logic [NUM_PNT*CODE_W-1:0] pnt_stem_in,
  input  logic [NUM_PNT*CODE_W-1:0] pnt_plus_in,
  input  logic [NUM_PNT*CODE_W-1:0] pnt_minus_in,
  input  logic [NUM_PNT*LIE_W-1:0]  pnt_lie,
  output logic [NUM_LIN-1:0]        lin_haz,
  output logic [NUM_PNT-1:0]        pnt_haz,
  output logic                      hazard
);
  localparam int PAD_W = (NUM_LIN + 1) * CODE_W;

  function automatic logic link_at(input int k);
    if (k < 0 || k > NUM_LIN - 2) return 1'b0;
    return LINK_UP[k];
  endfunction

  // padded copies: a quiet section beyond each end of the line
  logic [PAD_W-1:0] up_pad, dn_pad;
  assign up_pad = {{CODE_W{1'b0}}, occ_up};
  assign dn_pad = {occ_dn, {CODE_W{1'b0}}};

  // named internal events, visible to the checker
  logic [NUM_LIN-1:0] lin_evt, lin_h2h, lin_seam;
  logic [NUM_PNT-1:0] pnt_evt;
  logic               any_evt;

  for (genvar i = 0; i < NUM_LIN; i++) begin : g_lin
    localparam logic LNK_UP = link_at(i);
    localparam logic LNK_DN = link_at(i - 1);
    trk_lin_check u_lin (
      .occ_up   (up_pad[i*CODE_W +: CODE_W]),
      .occ_dn   (dn_pad[(i+1)*CODE_W +: CODE_W]),
      .up_ahead (up_pad[(i+1)*CODE_W +: CODE_W]),
      .dn_ahead (dn_pad[i*CODE_W +: CODE_W]),
      .link_up  (LNK_UP),
      .link_dn  (LNK_DN),
      .evt_h2h  (lin_h2h[i]),
      .evt_seam (lin_seam[i]),
      .evt      (lin_evt[i])
    );
  end

  for (genvar j = 0; j < NUM_PNT; j++) begin : g_pnt
    trk_pnt_check u_pnt (
      .lie      (pnt_lie[j*LIE_W +: LIE_W]),
      .stem_in  (pnt_stem_in[j*CODE_W +: CODE_W]),
      .plus_in  (pnt_plus_in[j*CODE_W +: CODE_W]),
      .minus_in (pnt_minus_in[j*CODE_W +: CODE_W]),
      .evt      (pnt_evt[j])
    );
  end

  assign any_evt = (|lin_evt) | (|pnt_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_haz <= '0;
      pnt_haz <= '0;
      hazard  <= 1'b0;
    end else begin
      lin_haz <= lin_evt;
      pnt_haz <= pnt_evt;
      hazard  <= hazard | any_evt;
    end
  end
endmodule

// File: rtl/trk_hazard_mon_chk.sv
module trk_hazard_mon_chk
  import trk_haz_pkg::*;
#(
  parameter int NUM_LIN = 6,
  parameter int NUM_PNT = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_LIN*CODE_W-1:0] occ_up,
  input logic [NUM_LIN*CODE_W-1:0] occ_dn,
  input logic [NUM_PNT*CODE_W-1:0] pnt_stem_in,
  input logic [NUM_PNT*CODE_W-1:0] pnt_plus_in,
  input logic [NUM_PNT*CODE_W-1:0] pnt_minus_in,
  input logic [NUM_PNT*LIE_W-1:0]  pnt_lie,
  input logic [NUM_LIN-1:0]        lin_evt,
  input logic [NUM_PNT-1:0]        pnt_evt,
  input logic [NUM_LIN-1:0]        lin_haz,
  input logic [NUM_PNT-1:0]        pnt_haz,
  input logic                      hazard
);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    hazard |=> hazard);

  a_r10_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hazard) |-> $past((|lin_evt) | (|pnt_evt)));

  for (genvar i = 0; i < NUM_LIN; i++) begin : g_lin_a
    a_r2_lin_set: assert property (@(posedge clk) disable iff (!rst_n)
      lin_evt[i] |=> lin_haz[i]);
    a_r2_lin_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !lin_evt[i] |=> !lin_haz[i]);
    a_r3_head_on: assert property (@(posedge clk) disable iff (!rst_n)
      ((|occ_up[i*CODE_W +: CODE_W]) && (|occ_dn[i*CODE_W +: CODE_W]))
        |=> lin_haz[i]);
  end

  for (genvar j = 0; j < NUM_PNT; j++) begin : g_pnt_a
    a_r2_pnt_set: assert property (@(posedge clk) disable iff (!rst_n)
      pnt_evt[j] |=> pnt_haz[j]);
    a_r2_pnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !pnt_evt[j] |=> !pnt_haz[j]);
    a_r4_plus_entry: assert property (@(posedge clk) disable iff (!rst_n)
      ((|pnt_plus_in[j*CODE_W +: CODE_W]) && (pnt_lie[j*LIE_W +: LIE_W] != LIE_PLUS))
        |=> pnt_haz[j]);
    a_r5_minus_entry: assert property (@(posedge clk) disable iff (!rst_n)
      ((|pnt_minus_in[j*CODE_W +: CODE_W]) && !pnt_lie[j*LIE_W])
        |=> pnt_haz[j]);
    a_r6_stem_entry: assert property (@(posedge clk) disable iff (!rst_n)
      ((|pnt_stem_in[j*CODE_W +: CODE_W]) && pnt_lie[j*LIE_W + 1])
        |=> pnt_haz[j]);
  end
endmodule

bind trk_hazard_mon trk_hazard_mon_chk #(
  .NUM_LIN (NUM_LIN),
  .NUM_PNT (NUM_PNT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .occ_up       (occ_up),
  .occ_dn       (occ_dn),
  .pnt_stem_in  (pnt_stem_in),
  .pnt_plus_in  (pnt_plus_in),
  .pnt_minus_in (pnt_minus_in),
  .pnt_lie      (pnt_lie),
  .lin_evt      (lin_evt),
  .pnt_evt      (pnt_evt),
  .lin_haz      (lin_haz),
  .pnt_haz      (pnt_haz),
  .hazard       (hazard)
);

// File: tb/sim_trk_hazard_mon.sv
`timescale 1ns/1ps
module sim_trk_hazard_mon;
  localparam int NL = 6;
  localparam int NP = 3;
  localparam logic [NL-2:0] LNK = 5'b11011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [2:0] bu [NL];
  logic [2:0] bd [NL];
  logic [2:0] bs [NP];
  logic [2:0] bp [NP];
  logic [2:0] bm [NP];
  logic [1:0] bl [NP];

  logic [NL*3-1:0] occ_up, occ_dn;
  logic [NP*3-1:0] st_in, pl_in, mi_in;
  logic [NP*2-1:0] lie;
  logic [NL-1:0]   lin_haz;
  logic [NP-1:0]   pnt_haz;
  logic            hazard;

  always_comb begin
    for (int k = 0; k < NL; k++) begin
      occ_up[k*3 +: 3] = bu[k];
      occ_dn[k*3 +: 3] = bd[k];
    end
    for (int k = 0; k < NP; k++) begin
      st_in[k*3 +: 3] = bs[k];
      pl_in[k*3 +: 3] = bp[k];
      mi_in[k*3 +: 3] = bm[k];
      lie[k*2 +: 2]   = bl[k];
    end
  end

  trk_hazard_mon #(.NUM_LIN(NL), .NUM_PNT(NP), .LINK_UP(LNK)) u0 (
    .clk(clk), .rst_n(rst_n), .occ_up(occ_up), .occ_dn(occ_dn),
    .pnt_stem_in(st_in), .pnt_plus_in(pl_in), .pnt_minus_in(mi_in),
    .pnt_lie(lie), .lin_haz(lin_haz), .pnt_haz(pnt_haz), .hazard(hazard));

  int n_chk = 0;
  int n_bad = 0;
  logic exp_stk = 1'b0;

  // reference model, written from the requirement text
  function automatic logic mid_body(input logic [2:0] c, input logic [2:0] mask);
    return (c & mask) == 3'b001;
  endfunction

  function automatic logic [NL-1:0] ref_lin();
    logic [NL-1:0] r;
    for (int i = 0; i < NL; i++) begin
      r[i] = (int'(bu[i]) * int'(bd[i])) > 0;                          // R3
      if (i < NL-1 && LNK[i])                                           // R7
        if (mid_body(bu[i], 3'b101) != mid_body(bu[i+1], 3'b011)) r[i] = 1'b1;
      if (i > 0 && LNK[i-1])                                            // R8
        if (mid_body(bd[i], 3'b101) != mid_body(bd[i-1], 3'b011)) r[i] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [NP-1:0] ref_pnt();
    logic [NP-1:0] r;
    for (int j = 0; j < NP; j++) begin
      int p;
      p = int'(bl[j]);
      r[j] = (p * int'(bp[j]) + (1 - (p & 1)) * int'(bm[j]) + (p >> 1) * int'(bs[j])) > 0;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_inputs();
    for (int k = 0; k < NL; k++) begin bu[k] = '0; bd[k] = '0; end
    for (int k = 0; k < NP; k++) begin bs[k] = '0; bp[k] = '0; bm[k] = '0; bl[k] = '0; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    clear_inputs();
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", "lin_haz in reset", int'(lin_haz), 0);
    chk("R1", "pnt_haz in reset", int'(pnt_haz), 0);
    chk("R1", "hazard in reset", int'(hazard), 0);
    rst_n = 1'b1;
    exp_stk = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1", "hazard after release", int'(hazard), 0);
  endtask

  // inputs already set at a falling edge; check after the next rising edge
  task automatic apply(input string tag);
    logic [NL-1:0] el;
    logic [NP-1:0] ep;
    el = ref_lin();
    ep = ref_pnt();
    exp_stk = exp_stk | (|el) | (|ep);
    @(posedge clk);
    @(negedge clk);
    chk(tag, "lin_haz", int'(lin_haz), int'(el));
    chk(tag, "pnt_haz", int'(pnt_haz), int'(ep));
    chk("R10", "hazard", int'(hazard), int'(exp_stk));
  endtask

  function automatic logic [2:0] rnd_code();
    return ($urandom % 4 == 0) ? 3'($urandom % 8) : 3'd0;
  endfunction

  initial begin : watchdog
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed_sink;
    seed_sink = $urandom(32'd2025);
    clear_inputs();
    do_reset();

    // R3 head-on on section 2
    @(negedge clk); clear_inputs(); bu[2] = 3'b001; bd[2] = 3'b001;
    apply("R3");

    // R11 single-direction 3'b111, consistent neighbours: no hazard
    do_reset();
    clear_inputs(); bu[2] = 3'b111;
    apply("R11");

    // R7 up seam broken: body without front in 0, nothing in 1
    clear_inputs(); bu[0] = 3'b011;
    apply("R7");
    // R7 consistent seam: no flag on lin_haz
    @(negedge clk); clear_inputs(); bu[0] = 3'b011; bu[1] = 3'b101;
    apply("R7");

    // R8 down seam broken across 4 -> 3
    @(negedge clk); clear_inputs(); bd[4] = 3'b011;
    apply("R8");

    // R9 no link between 2 and 3: broken-looking seam ignored
    do_reset();
    clear_inputs(); bu[2] = 3'b011; bd[3] = 3'b011;
    apply("R9");

    // R4 plus entry
    @(negedge clk); clear_inputs(); bl[0] = 2'd1; bp[0] = 3'b001;
    apply("R4");
    @(negedge clk); clear_inputs(); bl[0] = 2'd0; bp[0] = 3'b001;
    apply("R4");
    // R5 minus entry
    @(negedge clk); clear_inputs(); bl[1] = 2'd0; bm[1] = 3'b101;
    apply("R5");
    @(negedge clk); clear_inputs(); bl[1] = 2'd1; bm[1] = 3'b101;
    apply("R5");
    // R6 stem entry while moving, and not while set
    @(negedge clk); clear_inputs(); bl[2] = 2'd2; bs[2] = 3'b100;
    apply("R6");
    @(negedge clk); clear_inputs(); bl[2] = 2'd1; bs[2] = 3'b100;
    apply("R6");

    // R10 hold after causes vanish, R2 per-item bits clear
    @(negedge clk); clear_inputs();
    apply("R2");

    // random mix, with periodic reset
    for (int v = 0; v < 400; v++) begin
      if (v % 16 == 0) do_reset();
      for (int k = 0; k < NL; k++) begin bu[k] = rnd_code(); bd[k] = rnd_code(); end
      for (int k = 0; k < NP; k++) begin
        bs[k] = rnd_code(); bp[k] = rnd_code(); bm[k] = rnd_code();
        bl[k] = 2'($urandom % 3);
      end
      apply("R2");
      @(negedge clk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule